// File: doc/BRIEF.md
# I2C Read-Only Target with Three-Byte Readback Frame

This block is the read side of an I2C target. It watches SCL and SDA from the system clock, finds start, repeated start and stop conditions, and checks the first byte after every start. When that byte carries its address with the read direction bit set, it acknowledges. It then shifts out a three-byte frame with one bit per SCL low phase. The frame holds a 16-bit word, most significant byte first, followed by a status byte. The status byte tells the host which of two parallel word inputs supplied the data, and whether the high-speed flag was set.

If a start is followed by a byte of the form 0000_1xxx, the block treats it as the high-speed entry code. It leaves that byte unacknowledged and raises a high-speed flag. The flag survives repeated starts and is cleared by a stop. The block pulls SDA low through an open-drain enable, and the enable only changes a fixed number of system clocks after SCL falls. Write transactions are refused and otherwise ignored.

Top module: `i2c_rdback_target`

## Requirements
- R1: While reset is high and on the first cycle after it, `sda_oe` and `hs_mode` are 0.
- R2: A first byte after a start equal to {1,0,0,1,1,`strap_a0`,0} followed by a 1 in bit 0 (read) is acknowledged: SDA is held low during the 9th SCL high phase.
- R3: A first byte with any other address, or with the read bit 0, gets no acknowledge. SDA stays released until the next start or stop, so any further clocked byte reads as 0xFF.
- R4: A first byte whose upper five bits are 00001 is not acknowledged and sets `hs_mode`.
- R5: `hs_mode` stays set across repeated starts and is cleared by a stop.
- R6: After the address acknowledge the frame is sent MSB first, in this order: word bits 15..8, word bits 7..0, then the status byte. After the status byte, SDA stays released whatever the host answers.
- R7: The word is `temp_word` when `use_temp` is 1 and `data_word` otherwise. The status byte is {6'b0, hs_mode, use_temp}, with bit 0 naming the source and bit 1 the high-speed flag.
- R8: The word, the source bit and the status byte are captured on the address byte's last SCL rise. Input changes after that point do not alter the frame.
- R9: When the host leaves SDA high in the 9th clock after a data byte (no acknowledge), the block releases SDA and following clocked bytes read 0xFF until a new start.
- R10: `sda_oe` never changes while SCL is high. Each change is applied `OE_DELAY` system clocks after the synchronised SCL fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| strap_a0 | input | 1 | Address strap for the variable address bit |
| data_word | input | 16 | Live data word |
| temp_word | input | 16 | Temporary-register word |
| use_temp | input | 1 | 1 selects `temp_word` for the frame |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| hs_mode | output | 1 | High-speed flag |

## Verification
The assertions assume that the host keeps each SCL low phase longer than the synchroniser latency plus `OE_DELAY`, so that a scheduled enable change always lands while SCL is still low. They also assume that the host moves SDA only while SCL is low, except when it deliberately forms a start or a stop. The bench's host model holds SCL low and high for 20 system clocks each. It changes SDA only at the midpoint of a low phase, and forms starts and stops with SCL held high for a full half period, so every transaction stays within these assumptions.

// File: rtl/i2c_rdback_pkg.sv
package i2c_rdback_pkg;
  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 2 * BYTE_W;
  localparam int FRAME_BYTES = 3;
  localparam int BIT_CW      = $clog2(BYTE_W);
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_TX, ST_RACK, ST_WAIT
  } st_t;

  function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:3] == 5'b00001;
  endfunction

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic a0);
    return b[BYTE_W-1:1] == {5'b10011, a0, 1'b0};
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic hs, input logic src);
    return {6'b000000, hs, src};
  endfunction
endpackage

// File: rtl/i2c_rdback_sync.sv
module i2c_rdback_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rdback_drv.sv
module i2c_rdback_drv #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_fall,
  input  logic force_rel,
  input  logic want_low,
  output logic sda_oe
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);

  logic          pend;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || force_rel) begin
      pend   <= 1'b0;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (scl_fall) begin
      pend <= 1'b1;
      cnt  <= '0;
    end else if (pend) begin
      if (cnt == CW'(DELAY - 1)) begin
        sda_oe <= want_low;
        pend   <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_rdback_fsm.sv
module i2c_rdback_fsm
  import i2c_rdback_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              strap_a0,
  input  logic [WORD_W-1:0] data_word,
  input  logic [WORD_W-1:0] temp_word,
  input  logic              use_temp,
  output logic              want_low,
  output logic              force_rel,
  output logic              hs_mode,
  output st_t               st
);
  logic [BIT_CW-1:0] bitcnt;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] rx_sh, tx_sh, stat_q;
  logic [WORD_W-1:0] word_q;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte   = {rx_sh[BYTE_W-2:0], sda_s};
  assign force_rel = start_det | stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      hs_mode <= 1'b0;
      bitcnt  <= '0;
      idx     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      stat_q  <= '0;
      word_q  <= '0;
    end else if (stop_det) begin
      st      <= ST_IDLE;
      hs_mode <= 1'b0;
    end else if (start_det) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
    end else if (scl_rise) begin
      case (st)
        ST_ADDR: begin
          rx_sh <= rx_byte;
          if (bitcnt == BIT_CW'(BYTE_W - 1)) begin
            if (is_hs_code(rx_byte)) begin
              hs_mode <= 1'b1;
              st      <= ST_WAIT;
            end else if (addr_hit(rx_byte, strap_a0) && rx_byte[0]) begin
              word_q <= use_temp ? temp_word : data_word;
              stat_q <= status_byte(hs_mode, use_temp);
              st     <= ST_AACK;
            end else begin
              st <= ST_WAIT;
            end
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_AACK: begin
          tx_sh  <= word_q[WORD_W-1:BYTE_W];
          idx    <= '0;
          bitcnt <= '0;
          st     <= ST_TX;
        end
        ST_TX: begin
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
          if (bitcnt == BIT_CW'(BYTE_W - 1)) st <= ST_RACK;
          else bitcnt <= bitcnt + 1'b1;
        end
        ST_RACK: begin
          if (!sda_s && idx != IDX_W'(FRAME_BYTES - 1)) begin
            tx_sh  <= (idx == '0) ? word_q[BYTE_W-1:0] : stat_q;
            idx    <= idx + 1'b1;
            bitcnt <= '0;
            st     <= ST_TX;
          end else begin
            st <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_AACK: want_low = 1'b1;
      ST_TX:   want_low = ~tx_sh[BYTE_W-1];
      default: want_low = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_rdback_target.sv
module i2c_rdback_target
  import i2c_rdback_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OE_DELAY    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_a0,
  input  logic [WORD_W-1:0] data_word,
  input  logic [WORD_W-1:0] temp_word,
  input  logic              use_temp,
  output logic              sda_oe,
  output logic              hs_mode
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic want_low, force_rel;
  st_t  fsm_st;

  i2c_rdback_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rdback_fsm u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .strap_a0(strap_a0),
    .data_word(data_word), .temp_word(temp_word), .use_temp(use_temp),
    .want_low(want_low), .force_rel(force_rel), .hs_mode(hs_mode), .st(fsm_st)
  );

  i2c_rdback_drv #(.DELAY(OE_DELAY)) u_drv (
    .clk(clk), .rst(rst), .scl_fall(scl_fall), .force_rel(force_rel),
    .want_low(want_low), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2c_rdback_chk.sv
module i2c_rdback_chk
  import i2c_rdback_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic hs_mode,
  input st_t  fsm_st
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && !hs_mode));

  a_r2_drive_only_in_frame: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (fsm_st inside {ST_AACK, ST_TX, ST_RACK}));

  a_r3_wait_released: assert property (@(posedge clk) disable iff (rst)
    (fsm_st == ST_WAIT) |-> !sda_oe);

  a_r4_hs_not_acked: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> !sda_oe);

  a_r5_stop_clears_hs: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !hs_mode);

  a_r5_rstart_keeps_hs: assert property (@(posedge clk) disable iff (rst)
    (start_det && hs_mode) |=> hs_mode);

  a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_rdback_target i2c_rdback_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .hs_mode(hs_mode), .fsm_st(fsm_st)
);

// File: tb/i2c_rdback_target_tb.sv
module i2c_rdback_target_tb;
  localparam int H = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        strap_a0 = 1'b0;
  logic [15:0] data_word = '0;
  logic [15:0] temp_word = '0;
  logic        use_temp = 1'b0;
  logic        sda_oe, hs_mode;
  logic        sda_line;

  int checks = 0;
  int fails = 0;
  int r10_viol = 0;
  bit done = 0;
  logic oe_prev = 1'b0;
  logic scl_prev = 1'b1;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_rdback_target u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .strap_a0(strap_a0), .data_word(data_word), .temp_word(temp_word),
    .use_temp(use_temp), .sda_oe(sda_oe), .hs_mode(hs_mode)
  );

  // R10 monitor: enable must not move while the bus clock is high
  always @(negedge clk) begin
    if (!rst && scl_m && scl_prev && (sda_oe !== oe_prev)) r10_viol++;
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wt(H/2); sda_m = 1'b1; wt(H/2); scl_m = 1'b1;
    wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(H/2); sda_m = 1'b0; wt(H/2); scl_m = 1'b1;
    wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic clk_bit(input logic drv, output logic samp);
    wt(H/2); sda_m = drv; wt(H/2); scl_m = 1'b1;
    wt(H/2); samp = sda_line; wt(H/2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!give_ack, s);
  endtask

  function automatic logic [7:0] exp_addr(input logic a0, input logic rd);
    return {5'b10011, a0, 1'b0, rd};
  endfunction

  function automatic logic [7:0] exp_stat(input logic hs, input logic src);
    return {6'b000000, hs, src};
  endfunction

  initial begin
    logic ack;
    logic [7:0] b;
    logic [15:0] w;
    logic src, hs_exp;
    void'($urandom(32'h5eed_1c2b));
    wt(10);
    chk("R1 oe in reset", sda_oe, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 hs after reset", hs_mode, 0);
    wt(H);

    // constrained random transactions
    for (int it = 0; it < 40; it++) begin
      int kind;
      logic use_hs;
      kind      = $urandom % 3;
      use_hs    = 1'($urandom % 2);
      strap_a0  = 1'($urandom % 2);
      data_word = 16'($urandom);
      temp_word = 16'($urandom);
      use_temp  = 1'($urandom % 2);
      w   = use_temp ? temp_word : data_word;
      src = use_temp;
      hs_exp = 1'b0;
      bus_start();
      if (use_hs) begin
        send_byte({5'b00001, 3'($urandom)}, ack);
        chk("R4 master code not acked", ack, 0);
        chk("R4 hs flag set", hs_mode, 1);
        hs_exp = 1'b1;
        bus_start();
        chk("R5 hs kept on repeated start", hs_mode, 1);
      end
      if (kind == 0) begin
        send_byte(exp_addr(strap_a0, 1'b1), ack);
        chk("R2 address ack", ack, 1);
        data_word = 16'($urandom);
        temp_word = 16'($urandom);
        use_temp  = 1'($urandom % 2);
        recv_byte(1'b1, b); chk("R6 R8 high byte", b, w[15:8]);
        recv_byte(1'b1, b); chk("R6 R8 low byte", b, w[7:0]);
        recv_byte(1'b0, b); chk("R7 status byte", b, exp_stat(hs_exp, src));
      end else begin
        if (kind == 1) send_byte(exp_addr(~strap_a0, 1'b1), ack);
        else           send_byte(exp_addr(strap_a0, 1'b0), ack);
        chk("R3 no ack", ack, 0);
        recv_byte(1'b1, b); chk("R3 bus released", b, 8'hFF);
      end
      if (use_hs) chk("R5 hs held before stop", hs_mode, 1);
      bus_stop();
      chk("R5 hs cleared by stop", hs_mode, 0);
    end

    // directed: host refuses first data byte
    strap_a0 = 1'b1; data_word = 16'h00A5; use_temp = 1'b0;
    bus_start();
    send_byte(exp_addr(1'b1, 1'b1), ack);
    chk("R2 ack with strap high", ack, 1);
    recv_byte(1'b0, b); chk("R6 high byte before nack", b, 8'h00);
    recv_byte(1'b1, b); chk("R9 released after nack", b, 8'hFF);
    recv_byte(1'b1, b); chk("R9 still released", b, 8'hFF);
    bus_stop();

    // directed: host acknowledges the status byte as well
    strap_a0 = 1'b0; temp_word = 16'h0000; use_temp = 1'b1;
    bus_start();
    send_byte(exp_addr(1'b0, 1'b1), ack);
    chk("R2 ack with strap low", ack, 1);
    recv_byte(1'b1, b); chk("R7 temp high byte", b, 8'h00);
    recv_byte(1'b1, b); chk("R7 temp low byte", b, 8'h00);
    recv_byte(1'b1, b); chk("R7 status temp source", b, 8'h01);
    recv_byte(1'b0, b); chk("R6 nothing after status", b, 8'hFF);
    bus_stop();

    chk("R10 oe stable while scl high", r10_viol, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule